// File: doc/BRIEF.md
# SPI Opcode Command Engine

This block is a half-duplex SPI master for serial-flash style commands, driven by a byte-wide register bus. Software programs four things: an 8-bit command opcode, a count of bytes to send, a count of bytes to receive, and a chip-select index. It stores the outgoing payload in a 128-byte shared buffer window. One execute strobe then runs the whole command. The selected chip select drops, the opcode goes out, the payload bytes follow, and then the engine clocks in the requested number of reply bytes. The reply bytes are written back into the same buffer directly behind the payload.

Software polls a busy flag until the command has ended and then reads the reply out of the window. A rewind strobe resets the buffer pointer to index 0. Without a rewind, the next command picks up where the previous one stopped. The serial clock is the system clock divided by a parameter. Data runs in SPI mode 0, MSB first.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset every chip-select line is high, the serial clock is low, and the busy flag, opcode and both count registers read 0.
- R2: Registers are written with `bus_we`. Opcode is at 0x00, send count at 0x48, receive count at 0x4B, chip-select byte at 0x1D and buffer bytes at 0x80+index. A `bus_re` strobe returns the addressed byte on `bus_rdata` in the following cycle.
- R3: Writing a byte with bit 0 set to address 0x02 starts a command when idle. Busy reads 1 from the cycle after that write until the command ends. Busy appears as bit 0 of 0x4C and as bit 7 of 0x03.
- R4: On the wire, the opcode comes first, then send-count bytes taken from the buffer, then receive-count bytes. Bits go MSB first in mode 0: the clock idles low, MOSI changes after falling edges, and MISO is sampled on rising edges. The clock period is CLK_DIV system clocks.
- R5: Only the line chosen by the low two bits of 0x1D goes low. It stays low for the whole command, from before the first rising clock edge until after the last falling edge.
- R6: Received bytes are stored in the buffer starting at the index just after the last payload byte.
- R7: The counts are clamped so that they never exceed the 128-byte buffer. The effective send count is min(tx, 128). The effective receive count is min(rx, 128 minus the effective send count).
- R8: An execute write that arrives while busy has no effect. The running command neither restarts nor lengthens.
- R9: Writing bit 4 set to 0x02 while idle rewinds the buffer pointer to index 0. Without a rewind, the next command fetches its payload from the index where the previous command ended.
- R10: All eight bits of 0x1D are stored and read back. Only the low two bits choose the chip select.
- R11: With both counts at 0, a command sends exactly the 8 opcode bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register/buffer byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_re` |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
A slave model on the wire answers each byte position with a known pattern and records every byte the engine sends. The main command is run in several shapes:
- send plus receive, which separates payload order from reply placement;
- receive only, which shows the replies land from index 0;
- opcode only, which shows that no stray bytes are clocked;
- an oversized send with a large receive, and an oversized send on its own, which expose wrong clamp arithmetic.

A repeated execute strobe in mid-command shows whether the engine restarts. Back-to-back commands with and without the rewind strobe tell pointer reuse apart from pointer reset.

// File: rtl/sce_pkg.sv
`timescale 1ns/1ps
package sce_pkg;
  localparam logic [7:0] ADR_OPCODE = 8'h00;
  localparam logic [7:0] ADR_CMD    = 8'h02;
  localparam logic [7:0] ADR_FLAGS  = 8'h03;
  localparam logic [7:0] ADR_CSEL   = 8'h1D;
  localparam logic [7:0] ADR_TXN    = 8'h48;
  localparam logic [7:0] ADR_RXN    = 8'h4B;
  localparam logic [7:0] ADR_STAT   = 8'h4C;
  localparam int CMD_GO_BIT  = 0;
  localparam int CMD_REW_BIT = 4;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SHIFT,
    SQ_FETCH,
    SQ_END
  } sq_state_t;
endpackage

// File: rtl/sce_byte_ram.sv
`timescale 1ns/1ps
module sce_byte_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/sce_shifter.sv
`timescale 1ns/1ps
module sce_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic [7:0] rx_byte,
  output logic       done,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int DW   = (HALF < 2) ? 1 : $clog2(HALF);

  logic          active;
  logic          sclk_q;
  logic [7:0]    sh_out;
  logic [7:0]    sh_in;
  logic [2:0]    bitn;
  logic [DW-1:0] divc;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sclk_q <= 1'b0;
      sh_out <= 8'h00;
      sh_in  <= 8'h00;
      bitn   <= 3'd0;
      divc   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        sh_out <= tx_byte;
        bitn   <= 3'd0;
        divc   <= '0;
        sclk_q <= 1'b0;
      end else if (active) begin
        if (divc == DW'(HALF - 1)) begin
          divc   <= '0;
          sclk_q <= ~sclk_q;
          if (!sclk_q) begin
            sh_in <= {sh_in[6:0], miso};
          end else begin
            sh_out <= {sh_out[6:0], 1'b0};
            bitn   <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end
          end
        end else begin
          divc <= divc + DW'(1);
        end
      end
    end
  end

  assign sclk    = sclk_q;
  assign mosi    = sh_out[7];
  assign rx_byte = sh_in;

  // R4: clock rests low whenever no byte is being shifted
  assert_sclk_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !active |-> !sclk_q);
  // R4: a byte ends only right after a high clock phase
  assert_done_after_fall_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (!sclk_q && !active));
endmodule

// File: rtl/sce_sequencer.sv
`timescale 1ns/1ps
module sce_sequencer
  import sce_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int NUM_CS = 4,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rewind,
  input  logic [7:0]        opcode,
  input  logic [7:0]        tx_cnt,
  input  logic [7:0]        rx_cnt,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic [7:0]        ram_q,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              busy,
  output logic [NUM_CS-1:0] cs_n,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_addr,
  output logic [7:0]        ram_wdata
);
  localparam int CW = (IDX_W + 2 > 9) ? IDX_W + 2 : 9;

  sq_state_t         st;
  logic [CW-1:0]     tx_left, rx_left;
  logic [CW-1:0]     tx_w, rx_w, tx_eff, room, rx_eff;
  logic [IDX_W-1:0]  idx;
  logic              in_rx;
  logic              busy_q;
  logic [NUM_CS-1:0] cs_n_q;

  always_comb begin
    tx_w   = CW'(tx_cnt);
    rx_w   = CW'(rx_cnt);
    tx_eff = (tx_w > CW'(DEPTH)) ? CW'(DEPTH) : tx_w;
    room   = CW'(DEPTH) - tx_eff;
    rx_eff = (rx_w > room) ? room : rx_w;
  end

  always_comb begin
    sh_start  = 1'b0;
    sh_tx     = 8'h00;
    ram_we    = 1'b0;
    ram_addr  = idx;
    ram_wdata = sh_rx;
    case (st)
      SQ_IDLE: begin
        if (start) begin
          sh_start = 1'b1;
          sh_tx    = opcode;
        end
      end
      SQ_SHIFT: begin
        if (sh_done) begin
          ram_we = in_rx;
          if (tx_left == '0 && rx_left != '0) sh_start = 1'b1;
        end
      end
      SQ_FETCH: begin
        sh_start = 1'b1;
        sh_tx    = ram_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_IDLE;
      busy_q  <= 1'b0;
      cs_n_q  <= '1;
      tx_left <= '0;
      rx_left <= '0;
      idx     <= '0;
      in_rx   <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (rewind) idx <= '0;
          if (start) begin
            busy_q  <= 1'b1;
            cs_n_q  <= ~(NUM_CS'(1) << cs_sel);
            tx_left <= tx_eff;
            rx_left <= rx_eff;
            in_rx   <= 1'b0;
            st      <= SQ_SHIFT;
          end
        end
        SQ_SHIFT: begin
          if (sh_done) begin
            if (in_rx) idx <= idx + IDX_W'(1);
            if (tx_left != '0) begin
              tx_left <= tx_left - CW'(1);
              st      <= SQ_FETCH;
            end else if (rx_left != '0) begin
              rx_left <= rx_left - CW'(1);
              in_rx   <= 1'b1;
            end else begin
              st <= SQ_END;
            end
          end
        end
        SQ_FETCH: begin
          idx   <= idx + IDX_W'(1);
          in_rx <= 1'b0;
          st    <= SQ_SHIFT;
        end
        default: begin
          cs_n_q <= '1;
          busy_q <= 1'b0;
          st     <= SQ_IDLE;
        end
      endcase
    end
  end

  assign busy = busy_q;
  assign cs_n = cs_n_q;

  // R5: never more than one chip select low
  assert_single_cs_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_q));
  // R5: every line is released when busy drops
  assert_cs_release_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (&cs_n_q));
  // R3: an accepted execute raises busy on the next cycle
  assert_busy_rise_R3: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_IDLE && start) |=> busy_q);
  // R8: a repeated execute mid-byte leaves the remaining counts untouched
  assert_exec_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && st == SQ_SHIFT && !sh_done) |=>
      ($stable(tx_left) && $stable(rx_left) && busy_q));
  // R7: work left never exceeds the buffer
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((CW+1)'(tx_left) + (CW+1)'(rx_left) <= (CW+1)'(DEPTH)));
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
  import sce_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int CLK_DIV    = 4,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int IDX_W = $clog2(FIFO_DEPTH);
  localparam int CS_W  = $clog2(NUM_CS);

  logic [7:0]       op_q, txn_q, rxn_q, csel_q;
  logic             go_p, rew_p, busy;
  logic             win_hit;
  logic [7:0]       rd_reg;
  logic             rd_win;
  logic             sh_start, sh_done;
  logic [7:0]       sh_tx, sh_rx;
  logic             sq_we, ram_we;
  logic [IDX_W-1:0] sq_addr, ram_addr;
  logic [7:0]       sq_wdata, ram_wdata, ram_q;

  assign win_hit = bus_addr[7];
  assign go_p    = bus_we && (bus_addr == ADR_CMD) && bus_wdata[CMD_GO_BIT];
  assign rew_p   = bus_we && (bus_addr == ADR_CMD) && bus_wdata[CMD_REW_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= 8'h00;
      txn_q  <= 8'h00;
      rxn_q  <= 8'h00;
      csel_q <= 8'h00;
    end else if (bus_we) begin
      case (bus_addr)
        ADR_OPCODE: op_q   <= bus_wdata;
        ADR_TXN:    txn_q  <= bus_wdata;
        ADR_RXN:    rxn_q  <= bus_wdata;
        ADR_CSEL:   csel_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_reg <= 8'h00;
      rd_win <= 1'b0;
    end else if (bus_re) begin
      rd_win <= win_hit;
      case (bus_addr)
        ADR_OPCODE: rd_reg <= op_q;
        ADR_FLAGS:  rd_reg <= {busy, 7'b0};
        ADR_CSEL:   rd_reg <= csel_q;
        ADR_TXN:    rd_reg <= txn_q;
        ADR_RXN:    rd_reg <= rxn_q;
        ADR_STAT:   rd_reg <= {7'b0, busy};
        default:    rd_reg <= 8'h00;
      endcase
    end
  end

  assign bus_rdata = rd_win ? ram_q : rd_reg;

  assign ram_we    = busy ? sq_we    : (bus_we && win_hit);
  assign ram_addr  = busy ? sq_addr  : bus_addr[IDX_W-1:0];
  assign ram_wdata = busy ? sq_wdata : bus_wdata;

  sce_byte_ram #(.DEPTH(FIFO_DEPTH), .AW(IDX_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  sce_sequencer #(.DEPTH(FIFO_DEPTH), .IDX_W(IDX_W), .NUM_CS(NUM_CS), .CS_W(CS_W)) u_seq (
    .clk(clk), .rst(rst), .start(go_p), .rewind(rew_p),
    .opcode(op_q), .tx_cnt(txn_q), .rx_cnt(rxn_q), .cs_sel(csel_q[CS_W-1:0]),
    .ram_q(ram_q), .sh_done(sh_done), .sh_rx(sh_rx),
    .busy(busy), .cs_n(spi_cs_n), .sh_start(sh_start), .sh_tx(sh_tx),
    .ram_we(sq_we), .ram_addr(sq_addr), .ram_wdata(sq_wdata)
  );

  sce_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_tx), .rx_byte(sh_rx),
    .done(sh_done), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  // R3: serial clock toggles only while a command is running
  assert_sclk_needs_busy_R3: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> busy);
  // R5: a chip select is low whenever the serial clock is high
  assert_cs_during_clock_R5: assert property (@(posedge clk) disable iff (rst)
    spi_sclk |-> !(&spi_cs_n));
endmodule

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;
  localparam int NCS = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [7:0]     bus_addr = 8'h00;
  logic           bus_we = 1'b0;
  logic           bus_re = 1'b0;
  logic [7:0]     bus_wdata = 8'h00;
  logic [7:0]     bus_rdata;
  logic           spi_sclk, spi_mosi;
  logic           spi_miso = 1'b0;
  logic [NCS-1:0] spi_cs_n;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  spi_cmd_engine i_spi_cmd_engine (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  // slave model
  int        nbits = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] cap [300];
  logic [NCS-1:0] cs_seen = '0;
  time       last_rise = 0;
  time       last_period = 0;
  wire       sel = ~(&spi_cs_n);

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 29 + 60) & 255);
  endfunction

  always @(posedge sel) begin
    logic [7:0] p;
    nbits   = 0;
    cs_seen = ~spi_cs_n;
    p = pat(0);
    spi_miso = p[7];
  end

  always @(posedge spi_sclk) begin
    if (sel) begin
      sh = {sh[6:0], spi_mosi};
      nbits = nbits + 1;
      if (nbits % 8 == 0 && nbits / 8 <= 300) cap[nbits/8-1] = sh;
      last_period = $time - last_rise;
      last_rise = $time;
    end
  end

  always @(negedge spi_sclk) begin
    logic [7:0] p;
    if (sel) begin
      p = pat(nbits / 8);
      spi_miso = p[7 - (nbits % 8)];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h4C, s);
      if (s[0] == 1'b0) break;
    end
    chk(s[0] == 1'b0, "R3 busy clears", s, 0);
  endtask

  task automatic run(input logic [7:0] op, input int tx, input int rx,
                     input int cs, input bit rewind);
    logic [7:0] s;
    wr(8'h1D, {6'b101010, 2'(cs)});
    wr(8'h00, op);
    wr(8'h48, 8'(tx));
    wr(8'h4B, 8'(rx));
    if (rewind) wr(8'h02, 8'h10);
    wr(8'h02, 8'h01);
    rd(8'h4C, s);
    chk(s[0] == 1'b1, "R3 busy after execute", s, 1);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(spi_cs_n == '1, "R1 cs high", spi_cs_n, 4'hF);
    chk(spi_sclk == 1'b0, "R1 sclk low", spi_sclk, 0);
    rd(8'h4C, d); chk(d == 8'h00, "R1 status", d, 0);
    rd(8'h00, d); chk(d == 8'h00, "R1 opcode", d, 0);
    rd(8'h48, d); chk(d == 8'h00, "R1 txn", d, 0);
    rd(8'h4B, d); chk(d == 8'h00, "R1 rxn", d, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(8'h00, 8'h5E); rd(8'h00, d); chk(d == 8'h5E, "R2 opcode", d, 8'h5E);
    wr(8'h48, 8'h07); rd(8'h48, d); chk(d == 8'h07, "R2 txn", d, 8'h07);
    wr(8'h4B, 8'hC3); rd(8'h4B, d); chk(d == 8'hC3, "R2 rxn", d, 8'hC3);
    wr(8'h85, 8'h9A); rd(8'h85, d); chk(d == 8'h9A, "R2 buffer", d, 8'h9A);
    wr(8'h1D, 8'hA6); rd(8'h1D, d); chk(d == 8'hA6, "R10 csel byte", d, 8'hA6);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    wr(8'h80, 8'h11); wr(8'h81, 8'h22); wr(8'h82, 8'h33);
    run(8'h9F, 3, 4, 2, 1'b1);
    wait_idle();
    chk(nbits == 64, "R4 bit count", nbits, 64);
    chk(cap[0] == 8'h9F, "R4 opcode first", cap[0], 8'h9F);
    chk(cap[1] == 8'h11 && cap[2] == 8'h22 && cap[3] == 8'h33, "R4 payload order",
        {cap[1], cap[2], cap[3]}, 24'h112233);
    chk(last_period == 80, "R4 clock period", int'(last_period), 80);
    chk(cs_seen == 4'b0100, "R5 selected line", cs_seen, 4'b0100);
    chk(spi_cs_n == '1, "R5 released", spi_cs_n, 4'hF);
    for (int j = 0; j < 4; j++) begin
      rd(8'h83 + 8'(j), d);
      chk(d == pat(4 + j), "R6 reply placement", d, pat(4 + j));
    end
    rd(8'h03, d); chk(d[7] == 1'b0, "R3 flag bit idle", d, 0);
  endtask

  task automatic t_rx_only();
    logic [7:0] d;
    run(8'h03, 0, 3, 3, 1'b1);
    wait_idle();
    chk(cs_seen == 4'b1000, "R5 line 3", cs_seen, 4'b1000);
    chk(nbits == 32, "R4 rx only bits", nbits, 32);
    for (int j = 0; j < 3; j++) begin
      rd(8'h80 + 8'(j), d);
      chk(d == pat(1 + j), "R6 reply from 0", d, pat(1 + j));
    end
  endtask

  task automatic t_opcode_only();
    run(8'hB7, 0, 0, 0, 1'b1);
    wait_idle();
    chk(nbits == 8, "R11 opcode only bits", nbits, 8);
    chk(cap[0] == 8'hB7, "R11 opcode value", cap[0], 8'hB7);
    chk(cs_seen == 4'b0001, "R10 low bits select", cs_seen, 4'b0001);
  endtask

  task automatic t_clamp();
    logic [7:0] d;
    for (int i = 0; i < 120; i++) wr(8'h80 + 8'(i), 8'(i) ^ 8'h55);
    run(8'h0B, 120, 20, 1, 1'b1);
    wait_idle();
    chk(nbits == 129 * 8, "R7 rx clamp bits", nbits, 129 * 8);
    chk(cap[120] == (8'd119 ^ 8'h55), "R7 last payload", cap[120], 8'd119 ^ 8'h55);
    rd(8'hFF, d); chk(d == pat(128), "R7 last reply", d, pat(128));
    rd(8'hF8, d); chk(d == pat(121), "R7 first reply", d, pat(121));
    run(8'h0C, 200, 9, 1, 1'b1);
    wait_idle();
    chk(nbits == 129 * 8, "R7 tx clamp bits", nbits, 129 * 8);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    wr(8'h80, 8'hE1); wr(8'h81, 8'hE2);
    run(8'h42, 2, 2, 2, 1'b1);
    repeat (40) @(negedge clk);
    wr(8'h02, 8'h01);
    rd(8'h03, d); chk(d[7] == 1'b1, "R3 flag bit busy", d, 8'h80);
    wait_idle();
    chk(nbits == 40, "R8 no restart", nbits, 40);
    chk(cap[0] == 8'h42 && cap[1] == 8'hE1 && cap[2] == 8'hE2, "R8 bytes intact",
        {cap[0], cap[1], cap[2]}, 24'h42E1E2);
  endtask

  task automatic t_pointer();
    wr(8'h80, 8'hA1); wr(8'h81, 8'hA2);
    run(8'h20, 2, 1, 0, 1'b1);
    wait_idle();
    wr(8'h83, 8'h77);
    run(8'h21, 1, 0, 0, 1'b0);
    wait_idle();
    chk(cap[1] == 8'h77, "R9 continues without rewind", cap[1], 8'h77);
    run(8'h22, 1, 0, 0, 1'b1);
    wait_idle();
    chk(cap[1] == 8'hA1, "R9 rewind to 0", cap[1], 8'hA1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_rx_only();
    t_opcode_only();
    t_clamp();
    t_busy_ignore();
    t_pointer();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 190000);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule